// File: doc/BRIEF.md
# Dispatch-Group Store/Load Address Conflict Checker

This block keeps a small table of the stores that have entered the current dispatch group and tells the issue logic, in the same cycle, whether a candidate load would read bytes that one of those stores writes. Each store is described by an access size and two address operands. The first operand is either a register identifier or a constant offset, and a flag says which. The second operand is always a base register identifier. Access sizes arrive already encoded. The block does no opcode decoding.

A load candidate is presented with the same fields. The block compares it against every recorded store at once. It raises `hazard` when the operands match in order, when they match swapped, or when both first operands are constants on the same base register and the byte ranges intersect. Asserting `grpClear` when a group closes empties the table. A store presented in that same cycle becomes the first entry of the new group.

Top module: `grp_overlap_det`

## Requirements
- R1: After reset the table is empty and `hazard` is 0 for any load candidate.
- R2: A load whose first operand (value and constant flag) and base register both equal those of a recorded store raises `hazard`.
- R3: When both first operands are registers, a load whose first operand equals a store's base register and whose base register equals that store's first operand raises `hazard`. If either first operand is a constant, the swapped match does not apply.
- R4: For constant first operands on the same base register, with store offset S below load offset L, `hazard` is 1 exactly when S + store size > L. The sum is taken without wraparound.
- R5: For constant first operands on the same base register, with L <= S, `hazard` is 1 exactly when L + load size > S. The sum is taken without wraparound.
- R6: Constant offsets on different base registers, and byte ranges that only touch end to start, give `hazard` = 0.
- R7: `hazard` is 0 whenever `ldValid` is 0, and whenever no store is recorded.
- R8: A cycle with `grpClear` high empties the table. If `stValid` is also high in that cycle, that store becomes the only entry.
- R9: Up to 5 stores are recorded in one group, and every entry is checked. A store presented while 5 are held and `grpClear` is low is dropped.
- R10: The size fields carry log2 of the byte count: 0→1, 1→2, 2→4, 3→8, 4→16. Codes 5 to 7 are not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| grpClear | input | 1 | End of dispatch group: empty the table |
| stValid | input | 1 | A store is recorded this cycle |
| stSizeCode | input | 3 | Store size, log2 of bytes |
| stOpA | input | 16 | Store first operand: register id or constant offset |
| stOpAConst | input | 1 | 1 when `stOpA` is a constant offset |
| stBase | input | 5 | Store base register id |
| ldValid | input | 1 | A load candidate is presented |
| ldSizeCode | input | 3 | Load size, log2 of bytes |
| ldOpA | input | 16 | Load first operand: register id or constant offset |
| ldOpAConst | input | 1 | 1 when `ldOpA` is a constant offset |
| ldBase | input | 5 | Load base register id |
| hazard | output | 1 | Combinational conflict flag for the load candidate |

## Verification
The bench uses the default build: five entries, 16-bit offsets and 5-bit register ids. With these sizes every pair of store and load size codes can be crossed against every offset pair in a 20-byte window. The same crossing is repeated over the last bytes of the offset space, where a sum wider than 16 bits decides the result. Five entries are few enough that the bench can fill the table, probe each slot, and confirm that an extra store is dropped.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

  typedef struct packed {
    logic clr;
    logic wr;
  } tblStrobe_t;

  function automatic logic [4:0] sizeBytes(input logic [2:0] code);
    return 5'(5'd1 << code);
  endfunction

endpackage

// File: rtl/ovl_ctrl.sv
module ovl_ctrl #(
  parameter int DEPTH = 5,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    grpClear,
  input  logic                    stValid,
  output ovl_pkg::tblStrobe_t     strb,
  output logic [IDX_W-1:0]        wrIdx
);
  logic [CNT_W-1:0] count;
  logic             full;

  assign full     = (count == CNT_W'(DEPTH));
  assign strb.clr = grpClear;
  assign strb.wr  = stValid && (grpClear || !full);
  assign wrIdx    = grpClear ? '0 : IDX_W'(count);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (grpClear) begin
      count <= stValid ? CNT_W'(1) : '0;
    end else if (strb.wr) begin
      count <= count + CNT_W'(1);
    end
  end

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  a_r8_clear_empty: assert property (@(posedge clk) disable iff (!rstN)
    grpClear && !stValid |=> count == '0);
  a_r8_clear_with_store: assert property (@(posedge clk) disable iff (!rstN)
    grpClear && stValid |=> count == CNT_W'(1));
  a_r9_full_drop: assert property (@(posedge clk) disable iff (!rstN)
    !grpClear && full && stValid |=> $stable(count));
endmodule

// File: rtl/ovl_table.sv
module ovl_table #(
  parameter int DEPTH = 5,
  parameter int OFS_W = 16,
  parameter int REG_W = 5,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ovl_pkg::tblStrobe_t strb,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [2:0]          stSizeCode,
  input  logic [OFS_W-1:0]    stOpA,
  input  logic                stOpAConst,
  input  logic [REG_W-1:0]    stBase,
  input  logic                ldValid,
  input  logic [2:0]          ldSizeCode,
  input  logic [OFS_W-1:0]    ldOpA,
  input  logic                ldOpAConst,
  input  logic [REG_W-1:0]    ldBase,
  output logic                hazard
);
  logic [DEPTH-1:0]       vld;
  logic [2:0]             eSize  [DEPTH];
  logic [OFS_W-1:0]       eOpA   [DEPTH];
  logic [DEPTH-1:0]       eConst;
  logic [REG_W-1:0]       eBase  [DEPTH];
  logic [DEPTH-1:0]       hit;
  logic [OFS_W:0]         ldEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld <= '0;
    end else begin
      if (strb.clr) vld <= '0;
      if (strb.wr)  vld[wrIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eConst <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        eSize[i] <= '0;
        eOpA[i]  <= '0;
        eBase[i] <= '0;
      end
    end else if (strb.wr) begin
      eSize[wrIdx]  <= stSizeCode;
      eOpA[wrIdx]   <= stOpA;
      eConst[wrIdx] <= stOpAConst;
      eBase[wrIdx]  <= stBase;
    end
  end

  assign ldEnd = {1'b0, ldOpA} + (OFS_W+1)'(ovl_pkg::sizeBytes(ldSizeCode));

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic           exactM, commM, rangeM, sameBase;
    logic [OFS_W:0] stEnd;
    assign sameBase = (eBase[i] == ldBase);
    assign stEnd    = {1'b0, eOpA[i]} + (OFS_W+1)'(ovl_pkg::sizeBytes(eSize[i]));
    assign exactM   = sameBase && (eConst[i] == ldOpAConst) && (eOpA[i] == ldOpA);
    assign commM    = !eConst[i] && !ldOpAConst &&
                      (ldOpA == OFS_W'(eBase[i])) && (eOpA[i] == OFS_W'(ldBase));
    always_comb begin
      rangeM = 1'b0;
      if (sameBase && eConst[i] && ldOpAConst) begin
        if (eOpA[i] < ldOpA) rangeM = stEnd > {1'b0, ldOpA};
        else                 rangeM = ldEnd > {1'b0, eOpA[i]};
      end
    end
    assign hit[i] = vld[i] && (exactM || commM || rangeM);
  end

  assign hazard = ldValid && (|hit);

  a_r7_gated: assert property (@(posedge clk) disable iff (!rstN)
    hazard |-> ldValid && (vld != '0));
  a_r8_cleared: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.clr) && !$past(strb.wr) |-> vld == '0);
  a_r10_size_legal: assert property (@(posedge clk) disable iff (!rstN)
    strb.wr |-> stSizeCode <= 3'd4);
  a_r9_write_sets: assert property (@(posedge clk) disable iff (!rstN)
    strb.wr |=> vld[$past(wrIdx)]);
endmodule

// File: rtl/grp_overlap_det.sv
module grp_overlap_det #(
  parameter int DEPTH = 5,
  parameter int OFS_W = 16,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             grpClear,
  input  logic             stValid,
  input  logic [2:0]       stSizeCode,
  input  logic [OFS_W-1:0] stOpA,
  input  logic             stOpAConst,
  input  logic [REG_W-1:0] stBase,
  input  logic             ldValid,
  input  logic [2:0]       ldSizeCode,
  input  logic [OFS_W-1:0] ldOpA,
  input  logic             ldOpAConst,
  input  logic [REG_W-1:0] ldBase,
  output logic             hazard
);
  localparam int IDX_W = $clog2(DEPTH);

  ovl_pkg::tblStrobe_t strb;
  logic [IDX_W-1:0]    wrIdx;

  ovl_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .grpClear(grpClear), .stValid(stValid),
    .strb(strb), .wrIdx(wrIdx)
  );

  ovl_table #(.DEPTH(DEPTH), .OFS_W(OFS_W), .REG_W(REG_W)) table_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx),
    .stSizeCode(stSizeCode), .stOpA(stOpA), .stOpAConst(stOpAConst), .stBase(stBase),
    .ldValid(ldValid), .ldSizeCode(ldSizeCode), .ldOpA(ldOpA),
    .ldOpAConst(ldOpAConst), .ldBase(ldBase), .hazard(hazard)
  );
endmodule

// File: tb/grp_overlap_det_tb.sv
module grp_overlap_det_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        grpClear = 1'b0, stValid = 1'b0, stOpAConst = 1'b0;
  logic [2:0]  stSizeCode = '0, ldSizeCode = '0;
  logic [15:0] stOpA = '0, ldOpA = '0;
  logic [4:0]  stBase = '0, ldBase = '0;
  logic        ldValid = 1'b0, ldOpAConst = 1'b0;
  logic        hazard;
  int          nChk = 0, nFail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  grp_overlap_det dut_i (
    .clk(clk), .rstN(rstN), .grpClear(grpClear), .stValid(stValid),
    .stSizeCode(stSizeCode), .stOpA(stOpA), .stOpAConst(stOpAConst), .stBase(stBase),
    .ldValid(ldValid), .ldSizeCode(ldSizeCode), .ldOpA(ldOpA),
    .ldOpAConst(ldOpAConst), .ldBase(ldBase), .hazard(hazard)
  );

  function automatic bit refOvl(int so, int sc, int lo, int lc);
    if (so < lo) return (so + (1 << sc)) > lo;
    return (lo + (1 << lc)) > so;
  endfunction

  task automatic putStore(input bit clr, input bit st, input int code,
                          input int a, input bit c, input int b);
    grpClear = clr; stValid = st; stSizeCode = 3'(code);
    stOpA = 16'(a); stOpAConst = c; stBase = 5'(b);
    @(negedge clk);
    grpClear = 1'b0; stValid = 1'b0;
  endtask

  task automatic checkLd(input bit v, input int code, input int a, input bit c,
                         input int b, input bit exp, input string req);
    ldValid = v; ldSizeCode = 3'(code); ldOpA = 16'(a); ldOpAConst = c; ldBase = 5'(b);
    #1;
    nChk++;
    if (hazard !== exp) begin
      nFail++;
      $display("FAIL %s: hazard=%b expected=%b (ld a=%0d c=%0b b=%0d sz=%0d)",
               req, hazard, exp, a, c, b, code);
    end
    ldValid = 1'b0;
  endtask

  task automatic sweep(input int org);
    for (int so = 0; so < 20; so++)
      for (int sc = 0; sc < 5; sc++) begin
        putStore(1'b1, 1'b1, sc, org + so, 1'b1, 3);
        for (int lo = 0; lo < 20; lo++)
          for (int lc = 0; lc < 5; lc++)
            checkLd(1'b1, lc, org + lo, 1'b1, 3,
                    refOvl(org + so, sc, org + lo, lc),
                    (so < lo) ? "R4/R10" : "R5/R10");
      end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 / R7: empty table never flags
    checkLd(1'b1, 2, 100, 1'b1, 3, 1'b0, "R1");
    checkLd(1'b1, 0, 7, 1'b0, 3, 1'b0, "R7");
    // R2: exact register operands
    putStore(1'b1, 1'b1, 2, 7, 1'b0, 3);
    checkLd(1'b1, 2, 7, 1'b0, 3, 1'b1, "R2");
    checkLd(1'b1, 2, 7, 1'b0, 2, 1'b0, "R2");
    checkLd(1'b1, 2, 7, 1'b1, 3, 1'b0, "R2");
    // R3: commuted registers
    checkLd(1'b1, 2, 3, 1'b0, 7, 1'b1, "R3");
    checkLd(1'b1, 2, 3, 1'b1, 7, 1'b0, "R3");
    // R7: no candidate
    checkLd(1'b0, 2, 7, 1'b0, 3, 1'b0, "R7");
    // R6: different base, touching ranges
    putStore(1'b1, 1'b1, 4, 1000, 1'b1, 3);
    checkLd(1'b1, 4, 1000, 1'b1, 4, 1'b0, "R6");
    checkLd(1'b1, 0, 1016, 1'b1, 3, 1'b0, "R6");
    checkLd(1'b1, 3, 992, 1'b1, 3, 1'b0, "R6");
    checkLd(1'b1, 0, 1015, 1'b1, 3, 1'b1, "R4");
    // R9: fill five entries, probe each, drop the sixth
    putStore(1'b1, 1'b1, 0, 0, 1'b1, 1);
    for (int k = 2; k <= 5; k++) putStore(1'b0, 1'b1, 0, 0, 1'b1, k);
    for (int k = 1; k <= 5; k++) checkLd(1'b1, 0, 0, 1'b1, k, 1'b1, "R9");
    putStore(1'b0, 1'b1, 0, 0, 1'b1, 9);
    checkLd(1'b1, 0, 0, 1'b1, 9, 1'b0, "R9");
    // R8: clear alone empties; clear with store keeps only the new one
    putStore(1'b1, 1'b0, 0, 0, 1'b1, 1);
    checkLd(1'b1, 0, 0, 1'b1, 1, 1'b0, "R8");
    putStore(1'b0, 1'b1, 0, 0, 1'b1, 2);
    putStore(1'b1, 1'b1, 0, 0, 1'b1, 6);
    checkLd(1'b1, 0, 0, 1'b1, 2, 1'b0, "R8");
    checkLd(1'b1, 0, 0, 1'b1, 6, 1'b1, "R8");
    // R4 / R5 / R10 sweeps, mid range and top of the offset space
    sweep(1000);
    sweep(65516);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule